// File: doc/BRIEF.md
# Selectable-Depth Elastic Store

This block is a circular single-bit buffer that sits between two clock domains inside a jitter attenuator. Bits enter on every edge of a recovered, jittery write clock and leave on every edge of a smoothed read clock. The difference between the two pointers is the fill level. The block reports the fill level, minus the chosen nominal depth, as a signed phase error. An external rate-control loop uses that value to steer the read clock. That loop and the clock it drives are outside this block.

A 2-bit depth code, sampled in the read domain, selects one of four modes. The first is bypass, where the store is skipped. The other three hold the read pointer a nominal 16, 32 or 64 bit periods behind the write pointer. The usable circular length is always twice the nominal depth. A change of code recenters the read pointer at once. So does a fill level that reaches zero or the full circular length, and in that case a one-cycle overflow or underflow pulse is also raised. The write pointer crosses into the read domain in Gray code through a chain of synchronizer flops.

Top module: `elastic_bit_store`

## Requirements
- R1: While reset is asserted, and on the first read edge after it, `dout`, `ovf_pulse` and `unf_pulse` are 0 and `phase_err` is 0.
- R2: In store mode, with both clocks running from one source and no lost edges, `dout` after read edge n equals the `din` value sampled at write edge n-(N+2). N is 16 for code 01, 32 for code 10 and 64 for code 11.
- R3: In bypass (code 00), `dout` after read edge n equals the `din` value sampled at edge n. `ovf_pulse`, `unf_pulse` and `phase_err` stay 0.
- R4: The depth after reset is code 11 (N=64). Holding `depth_sel` at 11 through and after reset gives a latency of 66 cycles.
- R5: A new code on `depth_sel` takes effect at the read edge that first samples it. From that edge on, the latency is the new N+2, with no missing or repeated bits, whichever mode the block is coming from.
- R6: `phase_err` is the signed fill level minus N. If the read clock loses k edges (k < N), it settles at +k and the latency grows by k. If the write clock loses k edges (k < N), it settles at -k and the latency shrinks by k.
- R7: When the fill level reaches 2N, `ovf_pulse` is high for exactly one read cycle and `phase_err` is 0 in that cycle. The pointers are recentered, so the latency returns to N+2.
- R8: When the fill level falls to 0 or below, `unf_pulse` is high for exactly one read cycle and the pointers are recentered. `ovf_pulse` and `unf_pulse` are never high together.
- R9: The circular length is 2N. Losing 20 read edges overflows at N=16 but not at N=32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered write clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| din | input | 1 | Serial data bit, one per write edge |
| rclk | input | 1 | Smoothed read clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| depth_sel | input | 2 | Depth code: 00 bypass, 01 N=16, 10 N=32, 11 N=64 |
| dout | output | 1 | Serial data bit, one per read edge |
| ovf_pulse | output | 1 | One-cycle pulse: fill reached the circular length |
| unf_pulse | output | 1 | One-cycle pulse: fill reached zero |
| phase_err | output | PW (9) | Signed fill level minus nominal depth |

## Verification
A read pointer that is off by even one position shows up at once. `phase_err` holds a nonzero value on the first read edge after the synchronizer refreshes, and the output stream shifts against the delayed input, so the scoreboard trips on the first mismatched bit. A wrong limit or a wrong depth decode shows up within a few cycles of a forced clock stall. The flag either appears where it should not, or fails to appear where the fill level crosses 2N or 0. Mistakes in the recentering after a code change are exposed within N+2 cycles, when the scoreboard begins comparing against the new delay.

// File: rtl/es_pkg.sv
package es_pkg;

  typedef enum logic [1:0] {
    DEPTH_BYPASS = 2'b00,
    DEPTH_16     = 2'b01,
    DEPTH_32     = 2'b10,
    DEPTH_64     = 2'b11
  } depth_e;

  function automatic logic is_store(depth_e d);
    return d != DEPTH_BYPASS;
  endfunction

endpackage

// File: rtl/es_ptr_sync.sv
module es_ptr_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= gray_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      bin_out[i] = ^(stg[STAGES-1] >> i);
    end
  end

endmodule

// File: rtl/es_bit_ram.sv
module es_bit_ram #(
  parameter int unsigned AW = 7
) (
  input  logic          wclk,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic mem [DEPTH];

  always_ff @(posedge wclk) begin
    mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst) rdata <= 1'b0;
    else      rdata <= mem[raddr];
  end

endmodule

// File: rtl/es_read_ctrl.sv
module es_read_ctrl
  import es_pkg::*;
#(
  parameter int unsigned BASE_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = 7,
  parameter int unsigned PW          = 9
) (
  input  logic                 rclk,
  input  logic                 rrst,
  input  logic [1:0]           depth_sel,
  input  logic [PW-1:0]        wsync,
  input  logic                 din,
  input  logic                 ram_q,
  output logic [AW-1:0]        raddr,
  output logic                 dout,
  output logic                 ovf_pulse,
  output logic                 unf_pulse,
  output logic signed [PW-1:0] phase_err,
  output depth_e               active_mode
);

  localparam int unsigned CW = $clog2(SYNC_STAGES + 1);

  function automatic logic [PW-1:0] nominal(depth_e c);
    case (c)
      DEPTH_BYPASS: return '0;
      DEPTH_16:     return PW'(BASE_DEPTH);
      DEPTH_32:     return PW'(2 * BASE_DEPTH);
      default:      return PW'(4 * BASE_DEPTH);
    endcase
  endfunction

  depth_e        sel_e, next_mode;
  logic [PW-1:0] rptr, raddr_c, nom_cur, nom_new, lim_cur, fill;
  logic [CW-1:0] settle_cnt;
  logic          pend, ready, steady, is_ovf, is_unf, recenter;
  logic          pt_q, sel_pt;

  always_comb begin
    sel_e     = depth_e'(depth_sel);
    ready     = (settle_cnt == '0);
    next_mode = ready ? sel_e : active_mode;
    nom_cur   = nominal(active_mode);
    nom_new   = nominal(sel_e);
    lim_cur   = nom_cur << 1;
    fill      = wsync - rptr;
    steady    = ready && !pend && (sel_e == active_mode) && is_store(active_mode);
    is_ovf    = steady && ($signed(fill) >= $signed(lim_cur));
    is_unf    = steady && ($signed(fill) <= $signed(PW'(0)));
    recenter  = ready && is_store(sel_e) &&
                (pend || (sel_e != active_mode) || is_ovf || is_unf);
    raddr_c   = recenter ? (wsync - nom_new) : rptr;
    raddr     = raddr_c[AW-1:0];
    dout      = sel_pt ? pt_q : ram_q;
  end

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rptr        <= '0;
      active_mode <= DEPTH_64;
      settle_cnt  <= CW'(SYNC_STAGES);
      pend        <= 1'b1;
      ovf_pulse   <= 1'b0;
      unf_pulse   <= 1'b0;
      phase_err   <= '0;
      pt_q        <= 1'b0;
      sel_pt      <= 1'b0;
    end else begin
      if (!ready) begin
        settle_cnt <= settle_cnt - CW'(1);
      end else begin
        active_mode <= sel_e;
        pend        <= 1'b0;
      end
      rptr      <= raddr_c + PW'(1);
      ovf_pulse <= is_ovf;
      unf_pulse <= is_unf;
      pt_q      <= din;
      sel_pt    <= !is_store(next_mode);
      if (!ready || recenter || !is_store(next_mode)) phase_err <= '0;
      else                                            phase_err <= fill - nom_cur;
    end
  end

endmodule

// File: rtl/elastic_bit_store.sv
module elastic_bit_store
  import es_pkg::*;
#(
  parameter int unsigned BASE_DEPTH  = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MAX_LEN    = 8 * BASE_DEPTH,
  localparam int unsigned AW         = $clog2(MAX_LEN),
  localparam int unsigned PW         = AW + 2
) (
  input  logic                 wclk,
  input  logic                 wrst,
  input  logic                 din,
  input  logic                 rclk,
  input  logic                 rrst,
  input  logic [1:0]           depth_sel,
  output logic                 dout,
  output logic                 ovf_pulse,
  output logic                 unf_pulse,
  output logic signed [PW-1:0] phase_err
);

  logic [PW-1:0] wptr, wptr_nx, wgray, wsync;
  logic [AW-1:0] raddr;
  logic          ram_q;
  depth_e        active_mode;

  assign wptr_nx = wptr + PW'(1);

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wptr  <= '0;
      wgray <= '0;
    end else begin
      wptr  <= wptr_nx;
      wgray <= wptr_nx ^ (wptr_nx >> 1);
    end
  end

  es_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk     (rclk),
    .rst     (rrst),
    .gray_in (wgray),
    .bin_out (wsync)
  );

  es_bit_ram #(.AW(AW)) u_ram (
    .wclk  (wclk),
    .waddr (wptr[AW-1:0]),
    .wdata (din),
    .rclk  (rclk),
    .rrst  (rrst),
    .raddr (raddr),
    .rdata (ram_q)
  );

  es_read_ctrl #(
    .BASE_DEPTH  (BASE_DEPTH),
    .SYNC_STAGES (SYNC_STAGES),
    .AW          (AW),
    .PW          (PW)
  ) u_rd (
    .rclk        (rclk),
    .rrst        (rrst),
    .depth_sel   (depth_sel),
    .wsync       (wsync),
    .din         (din),
    .ram_q       (ram_q),
    .raddr       (raddr),
    .dout        (dout),
    .ovf_pulse   (ovf_pulse),
    .unf_pulse   (unf_pulse),
    .phase_err   (phase_err),
    .active_mode (active_mode)
  );

endmodule

// File: rtl/es_store_checker.sv
module es_store_checker
  import es_pkg::*;
#(
  parameter int unsigned PW = 9
) (
  input logic                 rclk,
  input logic                 rrst,
  input logic                 ovf,
  input logic                 unf,
  input logic signed [PW-1:0] phase_err,
  input depth_e               mode
);

  AST_RST_QUIET: assert property (@(posedge rclk) disable iff (rrst)
    $past(rrst) |-> (!ovf && !unf && phase_err == '0)); // R1

  AST_BYPASS_QUIET: assert property (@(posedge rclk) disable iff (rrst)
    (mode == DEPTH_BYPASS) |-> (!ovf && !unf && phase_err == '0)); // R3

  AST_OVF_SINGLE: assert property (@(posedge rclk) disable iff (rrst)
    ovf |=> !ovf); // R7

  AST_FLAG_RECENTER: assert property (@(posedge rclk) disable iff (rrst)
    (ovf || unf) |-> (phase_err == '0)); // R7

  AST_UNF_SINGLE: assert property (@(posedge rclk) disable iff (rrst)
    unf |=> !unf); // R8

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge rclk) disable iff (rrst)
    !(ovf && unf)); // R8

endmodule

bind elastic_bit_store es_store_checker #(.PW(PW)) u_chk (
  .rclk      (rclk),
  .rrst      (rrst),
  .ovf       (ovf_pulse),
  .unf       (unf_pulse),
  .phase_err (phase_err),
  .mode      (active_mode)
);

// File: tb/elastic_bit_store_test.sv
`timescale 1ns/1ps
module elastic_bit_store_test;

  localparam int PW = 9;

  logic clk = 1'b0;
  logic wrun = 1'b1, rrun = 1'b1;
  logic wclk, rclk;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [1:0] depth_sel = 2'b11;
  logic dout, ovf_pulse, unf_pulse;
  logic signed [PW-1:0] phase_err;

  always #2 clk = ~clk;
  assign wclk = clk & wrun;
  assign rclk = clk & rrun;

  elastic_bit_store uut (
    .wclk(wclk), .wrst(rst), .din(din),
    .rclk(rclk), .rrst(rst), .depth_sel(depth_sel),
    .dout(dout), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
    .phase_err(phase_err)
  );

  int    nchecks = 0, nerr = 0;
  int    lat = 66;
  bit    chk_en = 1'b0;
  string cur_req = "R4";
  int    ovf_seen = 0, unf_seen = 0;
  bit    q[$];

  task automatic check(bit ok, string req, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: drives one bit per cycle and pushes it as the expected item
  task automatic step(bit wr, bit rd);
    @(negedge clk);
    wrun = wr;
    rrun = rd;
    din  = 1'($urandom);
    if (wr) begin
      q.push_back(din);
      if (q.size() > 300) void'(q.pop_front());
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1);
  endtask

  // monitor: pops the expected bit at the delay the requirements give
  always @(posedge clk) begin
    #1;
    if (rrun && !rst) begin
      if (ovf_pulse) ovf_seen++;
      if (unf_pulse) unf_seen++;
      if (chk_en && q.size() > lat) begin
        bit exp_b;
        exp_b = q[q.size() - 1 - lat];
        check(dout === exp_b, cur_req, int'(dout), int'(exp_b));
      end
    end
  end

  initial begin
    #(4 * 150000);
    nchecks++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    // R1: reset state
    run(5);
    check(dout == 1'b0, "R1", int'(dout), 0);
    check(ovf_pulse == 1'b0 && unf_pulse == 1'b0, "R1", int'(ovf_pulse | unf_pulse), 0);
    check(phase_err == 0, "R1", int'(phase_err), 0);
    rst = 1'b0;
    q.delete();
    run(1);
    check(phase_err == 0 && !ovf_pulse && !unf_pulse, "R1", int'(phase_err), 0);

    // R4 / R2: default depth 64, latency 66
    run(75);
    chk_en = 1'b1;
    run(150);
    check(phase_err == 0, "R4", int'(phase_err), 0);

    // R5 / R2: change to 16 then 32, checked from the switching edge
    cur_req = "R5"; depth_sel = 2'b01; lat = 18;
    run(100);
    check(phase_err == 0, "R2", int'(phase_err), 0);
    cur_req = "R2"; depth_sel = 2'b10; lat = 34;
    run(100);

    // R3: bypass
    cur_req = "R3"; depth_sel = 2'b00; lat = 0;
    ovf_seen = 0; unf_seen = 0;
    run(60);
    check(phase_err == 0, "R3", int'(phase_err), 0);
    check(ovf_seen == 0 && unf_seen == 0, "R3", ovf_seen + unf_seen, 0);

    // R5: leave bypass
    cur_req = "R5"; depth_sel = 2'b01; lat = 18;
    run(60);

    // R6 / R9: lose 20 read edges at N=32, no overflow
    cur_req = "R2"; depth_sel = 2'b10; lat = 34;
    run(60);
    chk_en = 1'b0; ovf_seen = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    run(10);
    check(phase_err == 20, "R6", int'(phase_err), 20);
    check(ovf_seen == 0, "R9", ovf_seen, 0);
    cur_req = "R6"; lat = 54; chk_en = 1'b1;
    run(60);

    // R7 / R9: lose 20 read edges at N=16, overflow and recenter
    cur_req = "R5"; depth_sel = 2'b01; lat = 18;
    run(60);
    check(phase_err == 0, "R5", int'(phase_err), 0);
    chk_en = 1'b0; ovf_seen = 0; unf_seen = 0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    run(10);
    check(ovf_seen == 1, "R7", ovf_seen, 1);
    check(unf_seen == 0, "R8", unf_seen, 0);
    check(phase_err == 0, "R7", int'(phase_err), 0);
    cur_req = "R7"; chk_en = 1'b1;
    run(60);

    // R6: lose 8 write edges at N=16
    chk_en = 1'b0; unf_seen = 0;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
    run(10);
    check(phase_err == -8, "R6", int'(phase_err), -8);
    check(unf_seen == 0, "R6", unf_seen, 0);
    cur_req = "R6"; lat = 10; chk_en = 1'b1;
    run(40);

    // R8: recenter via code changes, then lose 20 write edges at N=16
    cur_req = "R5"; depth_sel = 2'b10; lat = 34;
    run(50);
    depth_sel = 2'b01; lat = 18;
    run(50);
    chk_en = 1'b0; ovf_seen = 0; unf_seen = 0;
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    check(unf_seen == 1, "R8", unf_seen, 1);
    check(ovf_seen == 0, "R8", ovf_seen, 0);
    run(5);
    depth_sel = 2'b10; lat = 34;
    run(10);
    check(phase_err == 0, "R8", int'(phase_err), 0);
    cur_req = "R8"; chk_en = 1'b1;
    run(60);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule